// File: doc/BRIEF.md
# Addressed CAN Receive Filter with Clock-Crossing Frame Queue

This block sits between a CAN controller that has already decoded whole frames and a processor that runs on a clock unrelated to the CAN clock. Each decoded frame carries an 11-bit standard identifier. The upper three identifier bits are a sequence number, and the lower eight bits name the destination node. In the data field, byte 0 names the sender, byte 1 is a command, and the remaining bytes are user payload. The block compares the destination against the local node address under a programmable mask. It keeps only the frames that match, so traffic for other nodes never reaches the processor.

Accepted frames are written into a dual-clock queue that holds eight frames. The queue moves its Gray-coded pointers between the two domains through two-flop synchronizers. On the processor side, an interrupt level stays high while at least one frame is waiting. Software reads the head frame through a small byte-wide register window and then writes a pop command. If a frame is accepted while the queue is full, it is dropped and a sticky overrun flag is set; software clears the flag by writing 1 to it.

Top module: `canrx_filter_fifo`

## Requirements
- R1: A valid frame is accepted only when ((id[7:0] XOR node_addr_i) AND addr_mask_i) is zero. A non-matching frame leaves the queue untouched and does not raise irq_o.
- R2: With addr_mask_i all zeros, a frame to any destination is accepted.
- R3: irq_o is high while the queue holds at least one frame. It drops once the last frame is popped.
- R4: Frames leave in arrival order, and eight frames can be held without loss.
- R5: A frame accepted while eight frames are queued is discarded, the queued frames are unchanged, and status bit 1 (overrun) becomes 1.
- R6: Writing register 0 with bit 1 set clears the overrun flag. A write to register 0 with bit 1 clear leaves the flag as it was.
- R7: Register read map:
  - Register 0 is status: bit 0 = frame waiting, bit 1 = overrun.
  - Register 1 is id[7:0].
  - Register 2 is {1'b0, id[10:8], len[3:0]}.
  - Registers 3 to 10 are data bytes 0 to 7, where byte k is frm_data_i[8k+7:8k]. Register 3 is therefore the source address and register 4 the command.
- R8: After reset, irq_o is 0 and status reads 0.
- R9: A write to register 0 with bit 0 set pops the head frame. On an empty queue it has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| can_clk_i | input | 1 | CAN-side clock |
| proc_clk_i | input | 1 | Processor-side clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| node_addr_i | input | 8 | Local node address (CAN domain, quasi-static) |
| addr_mask_i | input | 8 | Destination compare mask (CAN domain, quasi-static) |
| frm_valid_i | input | 1 | One-cycle strobe: a decoded frame is present |
| frm_id_i | input | 11 | Standard identifier of the frame |
| frm_len_i | input | 4 | Data length, 0 to 8 |
| frm_data_i | input | 64 | Data bytes, byte 0 in bits 7:0 |
| reg_addr_i | input | 4 | Register index |
| reg_we_i | input | 1 | Register write strobe (processor domain) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational from reg_addr_i) |
| irq_o | output | 1 | Frame-waiting interrupt level |

## Verification
An accepted frame is written at the CAN edge where frm_valid_i is sampled. Its pointer then needs two processor edges of synchronization, so irq_o and the status bit rise within three processor cycles. The bench waits eight processor cycles before it samples them. A pop takes effect at the processor edge that samples the write, and the head frame's registers change immediately after that edge. The freed slot becomes visible to the CAN side only after up to three CAN cycles, so the bench lets ten processor cycles pass after any pop before it sends a frame that depends on that space. The overrun flag crosses back as a toggle through two processor flops and an edge flop, and it is sampled after the same eight-cycle wait.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ID_W   = 11;
  localparam int LEN_W  = 4;
  localparam int NBYTES = 8;
  localparam int ADDR_W = 8;

  typedef struct packed {
    logic [ID_W-1:0]     id;
    logic [LEN_W-1:0]    len;
    logic [NBYTES*8-1:0] data;
  } rxf_frame_t;

  localparam int FRAME_W = $bits(rxf_frame_t);
endpackage

// File: rtl/rxf_sync2.sv
module rxf_sync2 #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/rxf_accept.sv
module rxf_accept #(
  parameter int ID_W   = 11,
  parameter int ADDR_W = 8
) (
  input  logic              valid_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [ADDR_W-1:0] node_i,
  input  logic [ADDR_W-1:0] mask_i,
  output logic              accept_o
);
  logic [ADDR_W-1:0] diff;

  assign diff     = (id_i[ADDR_W-1:0] ^ node_i) & mask_i;
  assign accept_o = valid_i && (diff == '0);
endmodule

// File: rtl/rxf_async_fifo.sv
module rxf_async_fifo #(
  parameter int W      = 79,
  parameter int AW     = 3
) (
  input  logic         wclk_i,
  input  logic         rclk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         full_o,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wbin_q, wgray_q, rbin_q, rgray_q;
  logic [PW-1:0] rgray_w, wgray_r;
  logic [PW-1:0] wbin_nx, rbin_nx;
  logic          do_wr, do_rd;

  // write domain
  assign full_o  = (wgray_q == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
  assign do_wr   = wr_i && !full_o;
  assign wbin_nx = wbin_q + PW'(do_wr);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_nx;
      wgray_q <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  always_ff @(posedge wclk_i) begin
    if (do_wr) mem_q[wbin_q[AW-1:0]] <= wdata_i;
  end

  // read domain
  assign empty_o = (rgray_q == wgray_r);
  assign do_rd   = rd_i && !empty_o;
  assign rbin_nx = rbin_q + PW'(do_rd);
  assign rdata_o = mem_q[rbin_q[AW-1:0]];

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_nx;
      rgray_q <= rbin_nx ^ (rbin_nx >> 1);
    end
  end

  rxf_sync2 #(.W(PW)) u_sync_r2w (.clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray_q), .q_o(rgray_w));
  rxf_sync2 #(.W(PW)) u_sync_w2r (.clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray_q), .q_o(wgray_r));

  assert_no_overflow_R5: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_i && full_o) |=> $stable(wbin_q));

  assert_no_underflow_R9: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_i && empty_o) |=> $stable(rbin_q));

  assert_wgray_step_R4: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);

  assert_rgray_step_R4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);
endmodule

// File: rtl/canrx_filter_fifo.sv
module canrx_filter_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH_LOG2 = 3
) (
  input  logic                can_clk_i,
  input  logic                proc_clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   node_addr_i,
  input  logic [ADDR_W-1:0]   addr_mask_i,
  input  logic                frm_valid_i,
  input  logic [ID_W-1:0]     frm_id_i,
  input  logic [LEN_W-1:0]    frm_len_i,
  input  logic [NBYTES*8-1:0] frm_data_i,
  input  logic [3:0]          reg_addr_i,
  input  logic                reg_we_i,
  input  logic [7:0]          reg_wdata_i,
  output logic [7:0]          reg_rdata_o,
  output logic                irq_o
);
  localparam logic [3:0] REG_STAT  = 4'd0;
  localparam logic [3:0] REG_IDLO  = 4'd1;
  localparam logic [3:0] REG_INFO  = 4'd2;
  localparam logic [3:0] REG_DATA0 = 4'd3;

  logic       accept, full, empty;
  rxf_frame_t wr_frame, rd_frame;
  logic       pop, ovr_clr;
  logic       ovr_tgl_q, ovr_tgl_s, ovr_tgl_d_q, ovr_q;

  rxf_accept #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_accept (
    .valid_i (frm_valid_i),
    .id_i    (frm_id_i),
    .node_i  (node_addr_i),
    .mask_i  (addr_mask_i),
    .accept_o(accept)
  );

  assign wr_frame = '{id: frm_id_i, len: frm_len_i, data: frm_data_i};

  rxf_async_fifo #(.W(FRAME_W), .AW(DEPTH_LOG2)) u_fifo (
    .wclk_i (can_clk_i),
    .rclk_i (proc_clk_i),
    .rst_ni (rst_ni),
    .wr_i   (accept),
    .wdata_i(wr_frame),
    .full_o (full),
    .rd_i   (pop),
    .rdata_o(rd_frame),
    .empty_o(empty)
  );

  // overrun event crosses as a toggle
  always_ff @(posedge can_clk_i or negedge rst_ni) begin
    if (!rst_ni)             ovr_tgl_q <= 1'b0;
    else if (accept && full) ovr_tgl_q <= ~ovr_tgl_q;
  end

  rxf_sync2 #(.W(1)) u_sync_ovr (.clk_i(proc_clk_i), .rst_ni(rst_ni), .d_i(ovr_tgl_q), .q_o(ovr_tgl_s));

  assign pop     = reg_we_i && (reg_addr_i == REG_STAT) && reg_wdata_i[0];
  assign ovr_clr = reg_we_i && (reg_addr_i == REG_STAT) && reg_wdata_i[1];

  always_ff @(posedge proc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_tgl_d_q <= 1'b0;
      ovr_q       <= 1'b0;
    end else begin
      ovr_tgl_d_q <= ovr_tgl_s;
      if (ovr_tgl_s != ovr_tgl_d_q) ovr_q <= 1'b1;   // set wins over clear
      else if (ovr_clr)             ovr_q <= 1'b0;
    end
  end

  assign irq_o = !empty;

  logic [2:0] byte_idx;
  logic [7:0] data_bytes [NBYTES];

  assign byte_idx = 3'(reg_addr_i - REG_DATA0);

  for (genvar g = 0; g < NBYTES; g++) begin : g_bytes
    assign data_bytes[g] = rd_frame.data[g*8 +: 8];
  end

  always_comb begin
    reg_rdata_o = 8'h00;
    if (reg_addr_i == REG_STAT)
      reg_rdata_o = {6'b0, ovr_q, !empty};
    else if (reg_addr_i == REG_IDLO)
      reg_rdata_o = rd_frame.id[7:0];
    else if (reg_addr_i == REG_INFO)
      reg_rdata_o = {1'b0, rd_frame.id[10:8], rd_frame.len};
    else if (reg_addr_i >= REG_DATA0 && reg_addr_i < REG_DATA0 + 4'(NBYTES))
      reg_rdata_o = data_bytes[byte_idx];
  end

  assert_ovr_sticky_R6: assert property (@(posedge proc_clk_i) disable iff (!rst_ni)
    (ovr_q && !ovr_clr) |=> ovr_q);

  assert_ovr_only_on_event_R5: assert property (@(posedge proc_clk_i) disable iff (!rst_ni)
    ($rose(ovr_q)) |-> $past(ovr_tgl_s != ovr_tgl_d_q));
endmodule

// File: tb/canrx_filter_fifo_test.sv
`timescale 1ns/1ps
module canrx_filter_fifo_test;
  logic        proc_clk = 0, can_clk = 0, rst_n = 0;
  logic [7:0]  node_addr = 8'h42, addr_mask = 8'hFF;
  logic        frm_valid = 0;
  logic [10:0] frm_id = '0;
  logic [3:0]  frm_len = '0;
  logic [63:0] frm_data = '0;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq;

  int n_checks = 0, n_fail = 0;

  always #4   proc_clk = ~proc_clk;   // 125 MHz
  always #6.5 can_clk  = ~can_clk;

  canrx_filter_fifo uut (
    .can_clk_i(can_clk), .proc_clk_i(proc_clk), .rst_ni(rst_n),
    .node_addr_i(node_addr), .addr_mask_i(addr_mask),
    .frm_valid_i(frm_valid), .frm_id_i(frm_id), .frm_len_i(frm_len), .frm_data_i(frm_data),
    .reg_addr_i(reg_addr), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pwait(input int n);
    repeat (n) @(negedge proc_clk);
  endtask

  task automatic send(input logic [10:0] id, input logic [3:0] len, input logic [63:0] d);
    @(negedge can_clk);
    frm_valid = 1; frm_id = id; frm_len = len; frm_data = d;
    @(negedge can_clk);
    frm_valid = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge proc_clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] v);
    @(negedge proc_clk);
    reg_addr = a; reg_wdata = v; reg_we = 1;
    @(negedge proc_clk);
    reg_we = 0; reg_wdata = '0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R8 irq", irq, 0);
    rd(0, v); check("R8 status", v, 8'h00);
  endtask

  task automatic t_filter_exact;
    logic [7:0] v;
    node_addr = 8'h42; addr_mask = 8'hFF;
    send(11'h543, 4'd5, 64'h0000_00EE_DD07_0911);
    pwait(8);
    check("R1 mismatch no irq", irq, 0);
    send(11'h342, 4'd5, 64'h0000_00EE_DD07_0911);
    pwait(8);
    check("R3 irq on frame", irq, 1);
    rd(1, v); check("R7 id low", v, 8'h42);
    rd(2, v); check("R7 seq/len", v, 8'h35);
    rd(3, v); check("R7 source", v, 8'h11);
    rd(4, v); check("R7 command", v, 8'h09);
    rd(7, v); check("R7 byte4", v, 8'hEE);
    wr(0, 8'h01); pwait(2);
    check("R3 irq drops after pop", irq, 0);
    rd(0, v); check("R1 only matching frame queued", v, 8'h00);
  endtask

  task automatic t_filter_partial;
    logic [7:0] v;
    node_addr = 8'h40; addr_mask = 8'hF0;
    send(11'h04A, 4'd1, 64'hA1);
    send(11'h05A, 4'd1, 64'hB2);
    pwait(8);
    rd(3, v); check("R1 partial mask accept", v, 8'hA1);
    wr(0, 8'h01); pwait(2);
    rd(0, v); check("R1 partial mask reject", v, 8'h00);
    pwait(10);
  endtask

  task automatic t_mask_zero;
    logic [7:0] v;
    node_addr = 8'h42; addr_mask = 8'h00;
    send(11'h099, 4'd2, 64'h5C);
    pwait(8);
    check("R2 irq", irq, 1);
    rd(1, v); check("R2 id", v, 8'h99);
    wr(0, 8'h01); pwait(10);
  endtask

  task automatic t_fill_overrun;
    logic [7:0] v;
    node_addr = 8'h42; addr_mask = 8'hFF;
    for (int i = 0; i < 8; i++) send(11'h042, 4'd8, 64'(8'h10 + i));
    pwait(8);
    rd(0, v); check("R4 full no overrun", v, 8'h01);
    send(11'h042, 4'd8, 64'hFF);
    pwait(8);
    rd(0, v); check("R5 overrun set", v, 8'h03);
    for (int i = 0; i < 8; i++) begin
      rd(3, v); check("R4 order", v, 8'(8'h10 + i));
      wr(0, 8'h01);
    end
    pwait(2);
    check("R5 extra frame discarded", irq, 0);
    pwait(10);
  endtask

  task automatic t_clear;
    logic [7:0] v;
    wr(0, 8'h00);
    rd(0, v); check("R6 zero write keeps flag", v, 8'h02);
    wr(0, 8'h02);
    rd(0, v); check("R6 cleared", v, 8'h00);
  endtask

  task automatic t_pop_empty;
    logic [7:0] v;
    wr(0, 8'h01); wr(0, 8'h01);
    rd(0, v); check("R9 pop on empty", v, 8'h00);
    pwait(10);
    send(11'h142, 4'd3, 64'h77);
    pwait(8);
    rd(3, v); check("R9 next frame intact", v, 8'h77);
    wr(0, 8'h01); pwait(2);
    check("R9 single frame only", irq, 0);
  endtask

  initial begin
    #1000000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #21 rst_n = 1;
    pwait(4);
    t_reset();
    t_filter_exact();
    t_filter_partial();
    t_mask_zero();
    t_fill_overrun();
    t_clear();
    t_pop_empty();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule